// File: doc/BRIEF.md
# Packed Colour Palette Memory with Channel Expansion

This block holds a 256-entry colour lookup table for a display pipeline. Entries are 16 bits wide and stored two per 32-bit word. The memory has 128 words, and the bus side addresses it by word. Software reads and writes the packed words exactly as they are stored. Byte enables allow one half-word, or a single byte, to be changed without touching the rest of the word.

The pixel side presents an 8-bit colour index every cycle. One clock later it receives 8-bit red, green and blue values. Each value is built from the 5-bit field in the selected entry, with three zero bits appended below it. The entry's top bit is an intensity flag; the block stores it and returns it on bus reads, but it has no effect on the colour outputs. A swap input exchanges the red and blue outputs for panels wired in blue-green-red order.

The bus decoder that places this memory in the address map sits outside this block, as does the pixel unpacker that produces the indices.

Top module: `palette_ram`

## Requirements
- R1: Word w holds entry 2w in bits [15:0] and entry 2w+1 in bits [31:16]. Bit 0 of the pixel index selects the half: 0 selects the low half and 1 the high half. Index bits [7:1] select the word.
- R2: Within an entry, red is taken from bits [4:0], green from bits [9:5] and blue from bits [14:10].
- R3: Entry bit 15 (intensity) has no effect on the colour outputs.
- R4: Each channel output equals its 5-bit field shifted left by three, so output bits [2:0] are always zero.
- R5: A bus read at word w returns the whole stored word unchanged, including bit 15 of each entry, on `bus_rdata` one cycle later. `bus_rdata` holds its value in cycles with no read. A read and a write to the same word in the same cycle return the old contents.
- R6: The colour outputs reflect the index presented one cycle earlier. A write and a lookup of the same entry in the same cycle produce the old colour; the new colour appears from the following lookup onward.
- R7: When `pix_bgr` is 1 in the lookup cycle, the red and blue outputs are exchanged; green is unaffected.
- R8: On a write, byte lane k (bits [8k+7:8k]) is updated only when `bus_be[k]` is 1. A write with all enables at 0 leaves the word unchanged.
- R9: While `rst_n` is low, `bus_rdata`, `pix_red`, `pix_green` and `pix_blue` are cleared to zero on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the palette window |
| bus_rd | input | 1 | Read strobe for the palette window |
| bus_word | input | 7 | Word index within the window (byte offset / 4) |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data, two packed entries |
| bus_rdata | output | 32 | Registered read data |
| pix_idx | input | 8 | Colour index for the lookup |
| pix_bgr | input | 1 | Exchange the red and blue outputs |
| pix_red | output | 8 | Expanded red channel |
| pix_green | output | 8 | Expanded green channel |
| pix_blue | output | 8 | Expanded blue channel |

## Verification
The assertions check four properties on every cycle. The low three bits of every channel output must be zero. The outputs must be cleared after a reset cycle. Read data must hold in cycles with no read. The colour outputs must stay unchanged while the index and swap input are steady and no write has landed. The field positions, the choice of half-word, the red/blue exchange, the byte-lane merging and the old-value result of a simultaneous write and lookup all depend on specific data. Only the bench's scenarios show these, by comparing the outputs against a model of the packed table.

// File: rtl/pal_pkg.sv
// Package: shared widths and the colour expansion function for the palette.
// Assumes an entry layout of three equal colour fields, low to high red,
// green, blue, followed by one flag bit that colour output ignores.
package pal_pkg;
    localparam int FIELD_W = 5;
    localparam int CHAN_W  = 8;
    localparam int SHIFT_W = CHAN_W - FIELD_W;
    localparam int ENTRY_W = 3 * FIELD_W + 1;

    typedef struct packed {
        logic [CHAN_W-1:0] red;
        logic [CHAN_W-1:0] green;
        logic [CHAN_W-1:0] blue;
    } rgb_t;

    // Expand one entry to full-width channels; optionally swap red and blue.
    function automatic rgb_t expand_entry(input logic [ENTRY_W-1:0] ent,
                                          input logic swap);
        rgb_t o;
        logic [CHAN_W-1:0] r8, g8, b8;
        r8 = {ent[0*FIELD_W +: FIELD_W], {SHIFT_W{1'b0}}};
        g8 = {ent[1*FIELD_W +: FIELD_W], {SHIFT_W{1'b0}}};
        b8 = {ent[2*FIELD_W +: FIELD_W], {SHIFT_W{1'b0}}};
        o.green = g8;
        o.red   = swap ? b8 : r8;
        o.blue  = swap ? r8 : b8;
        return o;
    endfunction
endpackage

// File: rtl/pal_store.sv
// Module: packed word store with one byte-enabled write port and two
// registered read ports (bus read and pixel read). Reads in the same cycle
// as a write to the same word return the old contents. The memory itself
// is not reset; only the read registers are.
module pal_store #(
    parameter int WORDS  = 128,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wbe,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ra_en,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] mem [WORDS];

    // Merge the enabled byte lanes of the write into the addressed word.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int k = 0; k < LANES; k++) begin
                if (wbe[k]) mem[waddr][8*k +: 8] <= wdata[8*k +: 8];
            end
        end
    end

    // Bus read register: loads on a read strobe, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)     ra_data <= '0;
        else if (ra_en) ra_data <= mem[ra_addr];
    end

    // Pixel read register: fetches the addressed word every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rb_data <= '0;
        else        rb_data <= mem[rb_addr];
    end
endmodule

// File: rtl/pal_lookup.sv
// Module: selects one entry out of a fetched packed word and expands it.
// Assumes the word arrives registered in the same cycle as the delayed
// half-select and swap bits registered here, which keeps the one-cycle
// lookup latency aligned.
module pal_lookup
    import pal_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int EPW = DATA_W / ENTRY_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(EPW)-1:0] half_sel,
    input  logic                   swap,
    input  logic [DATA_W-1:0]      word,
    output rgb_t                   rgb
);
    logic [$clog2(EPW)-1:0] half_q;
    logic                   swap_q;
    logic [ENTRY_W-1:0]     ent [EPW];

    // Delay the half-select and swap bits to line up with the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
            swap_q <= 1'b0;
        end else begin
            half_q <= half_sel;
            swap_q <= swap;
        end
    end

    // Split the packed word into its entries.
    for (genvar i = 0; i < EPW; i++) begin : g_split
        assign ent[i] = word[i*ENTRY_W +: ENTRY_W];
    end

    // Expand the chosen entry.
    always_comb rgb = expand_entry(ent[half_q], swap_q);
endmodule

// File: rtl/palette_ram.sv
// Module: palette memory top. The bus side sees packed raw words by word
// index; the pixel side sees an index and gets expanded colour one cycle
// later. Assumes the outer decoder has already qualified the strobes for
// this window.
module palette_ram
    import pal_pkg::*;
#(
    parameter int WORDS  = 128,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int EPW    = DATA_W / ENTRY_W,
    localparam int IDX_W  = ADDR_W + $clog2(EPW),
    localparam int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_word,
    input  logic [LANES-1:0]  bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    input  logic              pix_bgr,
    output logic [CHAN_W-1:0] pix_red,
    output logic [CHAN_W-1:0] pix_green,
    output logic [CHAN_W-1:0] pix_blue
);
    localparam int HSEL_W = IDX_W - ADDR_W;

    logic [DATA_W-1:0] pix_word;
    rgb_t              rgb;

    pal_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_wr),
        .waddr   (bus_word),
        .wbe     (bus_be),
        .wdata   (bus_wdata),
        .ra_en   (bus_rd),
        .ra_addr (bus_word),
        .ra_data (bus_rdata),
        .rb_addr (pix_idx[IDX_W-1:HSEL_W]),
        .rb_data (pix_word)
    );

    pal_lookup #(.DATA_W(DATA_W)) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_sel (pix_idx[HSEL_W-1:0]),
        .swap     (pix_bgr),
        .word     (pix_word),
        .rgb      (rgb)
    );

    // Drive the channel outputs from the expanded entry.
    assign pix_red   = rgb.red;
    assign pix_green = rgb.green;
    assign pix_blue  = rgb.blue;
endmodule

// File: rtl/pal_checker.sv
// Module: port-level assertions for palette_ram, attached with bind.
module pal_checker
    import pal_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_rdata,
    input logic [7:0]  pix_idx,
    input logic        pix_bgr,
    input logic [7:0]  pix_red,
    input logic [7:0]  pix_green,
    input logic [7:0]  pix_blue
);
    logic armed;
    logic was_rst;

    // Track one clean cycle out of reset and the previous reset level.
    always_ff @(posedge clk) begin
        armed   <= rst_n;
        was_rst <= !rst_n;
    end

    // R9: outputs are zero on the cycle after a reset edge.
    always @(posedge clk) begin
        if (was_rst === 1'b1) begin
            a_r9_reset_clear: assert (bus_rdata == '0 && pix_red == '0 &&
                                      pix_green == '0 && pix_blue == '0);
        end
    end

    // R4: expanded channels never carry low-order bits.
    a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (pix_red[2:0] == 3'b0 && pix_green[2:0] == 3'b0 &&
                   pix_blue[2:0] == 3'b0));

    // R5: read data holds when no read is issued.
    a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !bus_rd) |=> $stable(bus_rdata));

    // R6: steady index and swap with no intervening write give steady colour.
    a_r6_steady_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(bus_wr) && $stable(pix_idx) && $stable(pix_bgr))
        |=> ($stable(pix_red) && $stable(pix_green) && $stable(pix_blue)));
endmodule

bind palette_ram pal_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pix_idx   (pix_idx),
    .pix_bgr   (pix_bgr),
    .pix_red   (pix_red),
    .pix_green (pix_green),
    .pix_blue  (pix_blue)
);

// File: tb/palette_ram_bench.sv
// Bench: scoreboard of expected bus and pixel results against a packed model.
module palette_ram_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [6:0]  bus_word = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic        pix_bgr = 1'b0;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int vectors = 0;
    int fails = 0;
    logic [31:0] model [128];

    typedef struct {
        string       req;
        bit          is_pix;
        logic [31:0] exp;
    } exp_t;
    exp_t sb[$];

    palette_ram u_palette_ram (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_word(bus_word), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pix_idx(pix_idx), .pix_bgr(pix_bgr),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Expected colour word {0, red, green, blue} from the requirements.
    function automatic logic [31:0] pix_exp(input logic [31:0] w,
                                            input bit hi, input bit bgr);
        logic [15:0] e;
        logic [7:0] r, g, b;
        e = hi ? w[31:16] : w[15:0];
        r = {e[4:0], 3'b000};
        g = {e[9:5], 3'b000};
        b = {e[14:10], 3'b000};
        return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
    endfunction

    function automatic void push(input string req, input bit p,
                                 input logic [31:0] e);
        exp_t x;
        x.req = req; x.is_pix = p; x.exp = e;
        sb.push_back(x);
    endfunction

    // Driver: one cycle of stimulus; expectations use the model before the write.
    task automatic cyc(input bit wr, input logic [3:0] be, input int wa,
                       input logic [31:0] wd, input bit rd, input bit lk,
                       input int idx, input bit bgr,
                       input string rreq, input string lreq);
        bus_wr = wr; bus_be = be; bus_word = 7'(wa); bus_wdata = wd;
        bus_rd = rd; pix_idx = 8'(idx); pix_bgr = bgr;
        @(posedge clk);
        if (rd) push(rreq, 1'b0, model[wa]);
        if (lk) push(lreq, 1'b1, pix_exp(model[idx/2], idx[0], bgr));
        if (wr) for (int k = 0; k < 4; k++)
            if (be[k]) model[wa][8*k +: 8] = wd[8*k +: 8];
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    // Monitor: compare every expectation on the falling edge after its result.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t x;
            logic [31:0] act;
            x = sb.pop_front();
            act = x.is_pix ? {8'h00, pix_red, pix_green, pix_blue} : bus_rdata;
            vectors++;
            if (act !== x.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", x.req, act, x.exp);
            end
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs cleared while in reset.
        vectors++;
        if ({bus_rdata, pix_red, pix_green, pix_blue} !== '0) begin
            fails++;
            $display("FAIL R9: actual %h expected 0",
                     {bus_rdata, pix_red, pix_green, pix_blue});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Fill every word with a distinct pattern (full byte enables).
        for (int w = 0; w < 128; w++)
            cyc(1, 4'hF, w, (32'h9E37_79B9 * (w + 1)) ^ (w << 20), 0, 0, 0, 0,
                "R8", "R1");

        // R5 raw readback; R1 low/high entry choice; R7 swap on odd words.
        for (int w = 0; w < 128; w++) begin
            cyc(0, 4'h0, 0, 0, 1, 1, 2 * w, 0, "R5", "R1");
            cyc(0, 4'h0, 0, 0, 0, 1, 2 * w + 1, w[0], "R5", "R1_R7");
        end

        // R4 full-scale entry (0x7FFF) and R2/R3 red-only with intensity set.
        cyc(1, 4'hF, 5, 32'h801F_7FFF, 0, 0, 0, 0, "R8", "R4");
        cyc(0, 4'h0, 0, 0, 1, 1, 10, 0, "R5", "R4");
        cyc(0, 4'h0, 0, 0, 0, 1, 11, 0, "R5", "R2_R3");
        // R3: same colour fields without intensity must match entry 11.
        cyc(1, 4'hF, 6, 32'h001F_0000, 0, 0, 0, 0, "R8", "R3");
        cyc(0, 4'h0, 0, 0, 0, 1, 13, 0, "R5", "R3");
        // R2 green-only and blue-only entries; R7 swap on the blue one.
        cyc(1, 4'hF, 7, 32'h7C00_03E0, 0, 0, 0, 0, "R8", "R2");
        cyc(0, 4'h0, 0, 0, 0, 1, 14, 0, "R5", "R2");
        cyc(0, 4'h0, 0, 0, 0, 1, 15, 0, "R5", "R2");
        cyc(0, 4'h0, 0, 0, 0, 1, 15, 1, "R5", "R7");
        cyc(0, 4'h0, 0, 0, 0, 1, 14, 1, "R5", "R7");

        // R6: write plus lookup and read of the same word give old values.
        cyc(1, 4'hF, 8, 32'hAAAA_5555, 1, 1, 16, 0, "R5_R6", "R6");
        cyc(0, 4'h0, 0, 0, 1, 1, 16, 0, "R6", "R6");
        cyc(0, 4'h0, 0, 0, 0, 1, 17, 0, "R6", "R6");

        // R8: partial byte enables, then all enables off.
        cyc(1, 4'b0101, 9, 32'h1234_5678, 0, 0, 0, 0, "R8", "R8");
        cyc(0, 4'h0, 9, 0, 1, 1, 18, 0, "R8", "R8");
        cyc(1, 4'b1010, 9, 32'hFEDC_BA98, 0, 0, 0, 0, "R8", "R8");
        cyc(0, 4'h0, 9, 0, 1, 1, 19, 0, "R8", "R8");
        cyc(1, 4'b0000, 9, 32'hFFFF_FFFF, 0, 0, 0, 0, "R8", "R8");
        cyc(0, 4'h0, 9, 0, 1, 0, 0, 0, "R8", "R8");

        // R5: rdata holds with no read strobe (idle cycle then compare).
        push("R5", 1'b0, model[9]);
        @(negedge clk);

        // R9: reset in mid-run clears outputs again.
        rst_n = 1'b0;
        @(posedge clk);
        push("R9", 1'b0, 32'h0);
        push("R9", 1'b1, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule